// File: doc/BRIEF.md
# Latchable Reload Countdown Timer

A byte-wide, memory-mapped countdown timer that produces a periodic interrupt. The system clock is first divided by a fixed ratio; each divider tick decrements a hidden running count. When the count is about to pass from one to zero, it is refilled from the programmed reload value and a sticky interrupt flag is raised. The reload period in clocks is therefore the reload value times the divider ratio.

Software programs the reload value one byte at a time. Neither byte affects the running count until a start command copies the full value across at once, which also restarts the divider. The running count can never be read directly. A snapshot command freezes a copy of it in a latch, and the latch is then read back through the same two offsets that take the reload bytes on a write. The interrupt flag stays set until software writes the acknowledge offset.

Top module: `reload_timer`

## Requirements
- R1: After reset the interrupt output is 0, the latch reads back as 0x0000, and the running count is 0.
- R2: A write to offset 0x00 sets the low reload byte, and a write to offset 0x04 sets the high reload byte. Neither write changes the running count. The new value is used only at the next start command or the next refill.
- R3: Any write to offset 0x08 (start) loads the full reload value into the running count and restarts the clock divider from zero.
- R4: With divider ratio D, the running count changes only on every D-th clock after a start. After D clocks with the count at N (N > 1), the count becomes N-1.
- R5: A divider tick with the count at 1 refills the count from the reload value and sets the interrupt. With reload value R, the first interrupt appears R*D clocks after the start, and further interrupts follow every R*D clocks.
- R6: A write to offset 0x0C with data bit 0 set copies the running count into the latch. A write to 0x0C with bit 0 clear leaves the latch unchanged.
- R7: While read strobe is high, offset 0x00 returns the latched low byte and offset 0x04 returns the latched high byte. The value stays fixed while counting continues. Every other offset reads 0.
- R8: The interrupt is sticky. A write of any data to offset 0x10 clears it. If a refill happens in the same cycle as the clear, the interrupt stays set.
- R9: Until the first start command, the count stays at 0 and no interrupt is raised, whatever the reload value is.
- R10: If the count is 0 (for example after a start with reload value 0), it stays at 0 and raises no interrupt until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Read data, valid in the same cycle as rd_en |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The bench takes snapshots at cycle offsets that sit exactly on divider boundaries and on the refill cycle. A design whose divider is off by one clock shows the wrong count at the boundary. A design that refills one tick late shows 0 instead of the reload value. A design that borrows wrongly across the byte boundary returns the wrong high byte. Other checks target the following faults:
- a reload write that leaks into the running count;
- a count that starts running without a start command;
- a zero reload that fires on every tick;
- an acknowledge that wins over a refill in the same cycle;
- a latch that follows the live count or takes a snapshot when bit 0 is clear.

// File: rtl/rt_pkg.sv
package rt_pkg;
   localparam int unsigned OFS_LO   = 0;
   localparam int unsigned OFS_HI   = 4;
   localparam int unsigned OFS_GO   = 8;
   localparam int unsigned OFS_SNAP = 12;
   localparam int unsigned OFS_ACK  = 16;

   typedef enum logic [2:0] {
      RS_NONE,
      RS_LO,
      RS_HI,
      RS_GO,
      RS_SNAP,
      RS_ACK
   } rt_sel_e;

   function automatic rt_sel_e rt_decode(input int unsigned a);
      case (a)
         OFS_LO:   return RS_LO;
         OFS_HI:   return RS_HI;
         OFS_GO:   return RS_GO;
         OFS_SNAP: return RS_SNAP;
         OFS_ACK:  return RS_ACK;
         default:  return RS_NONE;
      endcase
   endfunction
endpackage

// File: rtl/rt_prescaler.sv
module rt_prescaler #(
   parameter int DIV_RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;

   if (DIV_RATIO < 1) begin : g_bad_ratio
      $error("rt_prescaler: DIV_RATIO must be at least 1");
   end

   if (DIV_RATIO == 1) begin : g_div1
      assign tick = run && !restart;
   end else begin : g_divn
      logic [PW-1:0] pre_q;
      logic          last;

      assign last = (pre_q == PW'(DIV_RATIO - 1));
      assign tick = run && !restart && last;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pre_q <= '0;
         end else if (restart) begin
            pre_q <= '0;
         end else if (run) begin
            pre_q <= last ? '0 : pre_q + PW'(1);
         end
      end

      // R4
      pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pre_q <= PW'(DIV_RATIO - 1));
   end
endmodule

// File: rtl/rt_counter.sv
module rt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] cur,
   output logic             armed,
   output logic             fire
);
   if (CNT_W < 2) begin : g_bad_width
      $error("rt_counter: CNT_W must be at least 2");
   end

   logic at_one;
   logic at_zero;

   assign at_one  = (cur == CNT_W'(1));
   assign at_zero = (cur == '0);
   assign fire    = tick && !go && at_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (go) begin
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else if (go) begin
         cur <= reload_val;
      end else if (tick && !at_zero) begin
         cur <= at_one ? reload_val : cur - CNT_W'(1);
      end
   end

   // R4
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !go) |=> $stable(cur));

   // R4
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !go && cur > CNT_W'(1)) |=> (cur == $past(cur) - CNT_W'(1)));

   // R10
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_zero && !go) |=> (cur == '0));

   // R9
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> !tick);
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rt_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int DIV_RATIO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int CNT_W = 2 * DATA_W;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("reload_timer: ADDR_W must reach offset 0x10");
   end

   rt_sel_e           sel;
   logic              go;
   logic              snap_we;
   logic              ack;
   logic [DATA_W-1:0] rel_lo_q;
   logic [DATA_W-1:0] rel_hi_q;
   logic [CNT_W-1:0]  reload_val;
   logic [CNT_W-1:0]  cur;
   logic [CNT_W-1:0]  latch_q;
   logic              armed;
   logic              tick;
   logic              fire;
   logic              irq_q;

   assign sel        = rt_decode(32'(addr));
   assign go         = wr_en && (sel == RS_GO);
   assign snap_we    = wr_en && (sel == RS_SNAP) && wr_data[0];
   assign ack        = wr_en && (sel == RS_ACK);
   assign reload_val = {rel_hi_q, rel_lo_q};
   assign irq        = irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rel_lo_q <= '0;
         rel_hi_q <= '0;
      end else if (wr_en) begin
         if (sel == RS_LO) rel_lo_q <= wr_data;
         if (sel == RS_HI) rel_hi_q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (snap_we) begin
         latch_q <= cur;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (fire) begin
         irq_q <= 1'b1;
      end else if (ack) begin
         irq_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (sel)
            RS_LO:   rd_data = latch_q[DATA_W-1:0];
            RS_HI:   rd_data = latch_q[CNT_W-1:DATA_W];
            default: rd_data = '0;
         endcase
      end
   end

   rt_prescaler #(.DIV_RATIO(DIV_RATIO)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (armed),
      .restart (go),
      .tick    (tick)
   );

   rt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .tick       (tick),
      .reload_val (reload_val),
      .cur        (cur),
      .armed      (armed),
      .fire       (fire)
   );

   // R8
   ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !fire) |=> !irq);

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> irq);

   // R5
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fire));

   // R6
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_we |=> $stable(latch_q));
endmodule

// File: tb/reload_timer_tb.sv
module reload_timer_tb_top;
   localparam int ADDR_W = 5;
   localparam int DATA_W = 8;
   localparam int DIV    = 4;
   localparam int NVEC   = 9;

   // fields: reload[40:25], clocks since start m[24:17], expected snapshot[16:1], expected irq[0]
   localparam logic [40:0] VEC [NVEC] = '{
      {16'd10,     8'd1,  16'd10,     1'b0},
      {16'd10,     8'd3,  16'd10,     1'b0},
      {16'd10,     8'd4,  16'd9,      1'b0},
      {16'd10,     8'd39, 16'd1,      1'b0},
      {16'd10,     8'd40, 16'd10,     1'b1},
      {16'h1234,   8'd9,  16'h1232,   1'b0},
      {16'd3,      8'd13, 16'd3,      1'b1},
      {16'd3,      8'd17, 16'd2,      1'b1},
      {16'h0100,   8'd4,  16'h00FF,   1'b0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              rd_en = 1'b0;
   logic [DATA_W-1:0] rd_data;
   logic              irq;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   reload_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_RATIO(DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input int a, input logic [7:0] d);
      addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wr_data = '0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      addr = ADDR_W'(a); rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0; addr = '0;
   endtask

   task automatic read16(output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(0, lo);
      rd(4, hi);
      v = {hi, lo};
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_reload(input logic [15:0] r);
      wr(0, r[7:0]);
      wr(4, r[15:8]);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(50000 * 10);
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=done");
      finish_run();
   end

   initial begin
      logic [15:0] v, v0;
      logic [7:0]  b;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      chk("R1 irq after reset", 32'(irq), 0);
      read16(v);
      chk("R1 latch after reset", 32'(v), 0);

      // R9 no start yet: count idle at 0, no irq
      set_reload(16'd2);
      wait_n(20);
      chk("R9 no irq before start", 32'(irq), 0);
      wr(12, 8'h01);
      read16(v);
      chk("R9 count idle before start", 32'(v), 0);
      rd(8, b);
      chk("R7 unmapped offset reads 0", 32'(b), 0);

      // R3 R4 R5 R7 table: start, ack, wait, check irq, snapshot
      for (int k = 0; k < NVEC; k++) begin
         logic [15:0] r, e;
         int m;
         r = VEC[k][40:25];
         m = int'(VEC[k][24:17]);
         e = VEC[k][16:1];
         set_reload(r);
         wr(8, 8'h00);
         wr(16, 8'h00);
         wait_n(m - 1);
         chk("R5 irq at table point", 32'(irq), 32'(VEC[k][0]));
         wr(12, 8'h01);
         read16(v);
         chk("R4 snapshot at table point", 32'(v), 32'(e));
      end

      // R8 sticky irq, clear, set-wins
      set_reload(16'd5);
      wr(8, 8'h00);
      wr(16, 8'h00);
      wait_n(18);
      chk("R5 no irq one clock early", 32'(irq), 0);
      wait_n(1);
      chk("R5 irq at R*D", 32'(irq), 1);
      wait_n(10);
      chk("R8 irq sticky", 32'(irq), 1);
      wr(16, 8'h00);
      chk("R8 ack clears irq", 32'(irq), 0);
      wait_n(8);
      wr(16, 8'h00);
      chk("R8 refill beats ack", 32'(irq), 1);

      // R6 R7 snapshot holds, bit0 clear ignored
      set_reload(16'd10);
      wr(8, 8'h00);
      wr(16, 8'h00);
      wait_n(5);
      wr(12, 8'h01);
      read16(v0);
      chk("R6 snapshot value", 32'(v0), 9);
      wait_n(10);
      read16(v);
      chk("R7 latch steady while counting", 32'(v), 32'(v0));
      wr(12, 8'h00);
      read16(v);
      chk("R6 bit0 clear ignored", 32'(v), 32'(v0));

      // R2 reload write does not touch running count until refill
      set_reload(16'd2);
      wr(8, 8'h00);
      wr(16, 8'h00);
      set_reload(16'd7);
      wait_n(2);
      wr(12, 8'h01);
      rd(0, b);
      chk("R2 count unaffected by reload write", 32'(b), 1);
      rd(4, b);
      wait_n(1);
      wr(12, 8'h01);
      read16(v);
      chk("R2 refill uses new reload", 32'(v), 7);

      // R10 zero reload holds at zero
      set_reload(16'd0);
      wr(8, 8'h00);
      wr(16, 8'h00);
      wait_n(30);
      chk("R10 no irq with zero reload", 32'(irq), 0);
      wr(12, 8'h01);
      read16(v);
      chk("R10 count stays zero", 32'(v), 0);

      finish_run();
   end
endmodule